// File: doc/BRIEF.md
# Dual-Lane Memory Self-Test Controller

This block exercises an external word-wide static RAM made of two byte-wide halves and finds the first defect it can classify. After a start pulse it probes a single word for a half that never drives the bus and for a half that ignores writes. It then sweeps four fill values over every word and finally walks a marker through each power-of-two address to expose address lines that are tied low. Each half of the word is judged on its own, so a defect is reported against the half that caused it.

The first defect ends the run. A seven-bit fault code, the word address involved, a fail flag and a done flag are held until reset. A pause input freezes the sweep between memory accesses, so a host can stop and inspect the RAM and resume without losing its place. The RAM port is synchronous: an access is issued for one cycle, and read data is taken on the cycle after the read enable.

Top module: `dual_lane_memtest`

## Requirements
- R1: Once reset has been released, busy, done and fail are low, fail_code is 0000000 and neither mem_we nor mem_oe is asserted.
- R2: A start pulse while idle raises busy on the next cycle. A run with no defect ends with done high, busy low, fail low and fail_code 0000000. busy and done are never high together.
- R3: Dead half. Word 0 is written with 0x0000 and read back, then written with 0x5555 and read back. A half whose byte reads 0xFF after both writes is dead: code 1000100 for bits 7:0 and 1000101 for bits 15:8. The lower half is checked first, and fail_addr is 0.
- R4: Unwritable half. Word 0 is written with 0x0000 and with 0xFFFF. A half that returns the same byte after both writes is unwritable: code 1110000 for bits 7:0 and 1110001 for bits 15:8. The lower half is checked first, and fail_addr is 0.
- R5: Fill sweeps run in the order 0x0000, 0x5555, 0xAAAA, 0xFFFF. Each sweep writes every word and then reads every word back. The first mismatch in either half reports 1001000, 1001001, 1001010 or 1001011 for the active fill value, with fail_addr set to the failing word.
- R6: Address walk. Word 0 gets marker {0x00,0xFF}, and word 2^i gets marker {i+1, ~(i+1)}. Each 2^i is read back first, then word 0. A mismatch at 2^i blames line i. A mismatch at word 0 blames line (upper byte read − 1). Lines 0–7 report 1010000, and any other line or an undecodable tag reports 1010001. fail_addr is the word that was read.
- R7: On a defect, fail and done rise on the same cycle. fail, fail_code and fail_addr then hold, and start pulses are ignored (busy stays low) until reset.
- R8: While pause is high, mem_we and mem_oe stay low. From the second paused cycle onward, mem_addr holds. Releasing pause resumes at the same step, and a pause of P cycles lengthens a run by P or P−1 cycles.
- R9: mem_we and mem_oe are never high together. mem_be is 11 whenever either is high. Read data is sampled one cycle after mem_oe.
- R10: A start pulse after a run that passed begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (pulse) |
| pause | input | 1 | Freeze the sweep between accesses |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_oe |
| mem_we | output | 1 | Write strobe |
| mem_oe | output | 1 | Read strobe |
| mem_be | output | 2 | Byte-half enables, bit 1 = bits 15:8 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run stopped on a defect |
| fail_code | output | 7 | Fault class code |
| fail_addr | output | AW | Word address tied to the fault |

## Verification
The assertions take it for granted that the RAM answers a read with data on the following cycle and holds that value until the next read. They also assume pause is held for whole cycles and that reset is asserted before the first run. The bench's RAM model registers its read data only on mem_oe, and it drives start and pause on the falling clock edge, so every input is stable across the rising edge. Defects are injected one per run, after a fresh reset, so only one fault class is present at a time.

// File: rtl/memtest_pkg.sv
// Shared step encoding, fault codes and data-word helpers for the memory self-test.
// Assumes a 16-bit word split into two byte halves.
package memtest_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRB_W, ST_PRB_R, ST_PRB_C,
        ST_PAT_W, ST_PAT_R, ST_PAT_C,
        ST_ADR_W0, ST_ADR_WL, ST_ADR_RL, ST_ADR_CL, ST_ADR_R0, ST_ADR_C0,
        ST_FIN
    } step_t;

    localparam logic [6:0] CODE_NONE   = 7'b0000000;
    localparam logic [6:0] CODE_DEAD   = 7'b1000100;  // | half
    localparam logic [6:0] CODE_FROZEN = 7'b1110000;  // | half
    localparam logic [6:0] CODE_FILL   = 7'b1001000;  // | fill index
    localparam logic [6:0] CODE_ALO    = 7'b1010000;
    localparam logic [6:0] CODE_AHI    = 7'b1010001;

    localparam logic [7:0] FLOAT_BYTE  = 8'hFF;
    localparam int         LOW_LINES   = 8;

    // Probe words for word 0: dead check uses 0,1; writability uses 2,3.
    function automatic logic [15:0] probe_word(input logic [1:0] idx);
        case (idx)
            2'd1:    probe_word = 16'h5555;
            2'd3:    probe_word = 16'hFFFF;
            default: probe_word = 16'h0000;
        endcase
    endfunction

    // Fill value for sweep index 0..3.
    function automatic logic [15:0] fill_word(input logic [1:0] idx);
        case (idx)
            2'd0:    fill_word = 16'h0000;
            2'd1:    fill_word = 16'h5555;
            2'd2:    fill_word = 16'hAAAA;
            default: fill_word = 16'hFFFF;
        endcase
    endfunction

    // Address-walk marker: tag in the upper half, its complement below.
    function automatic logic [15:0] marker_word(input logic [7:0] tag);
        marker_word = {tag, ~tag};
    endfunction

endpackage

// File: rtl/memtest_ctr.sv
// Up-counter with clear priority and a terminal flag at LIMIT.
// Assumes LIMIT fits in W bits.
module memtest_ctr #(
    parameter int          W     = 8,
    parameter int unsigned LIMIT = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         at_last
);
    // Count register: clear wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end

    // Terminal value flag.
    assign at_last = (q == W'(LIMIT));
endmodule

// File: rtl/memtest_lane.sv
// Judge for one byte half: compares a read against the expected byte and
// keeps an earlier read to spot floating or write-ignoring halves.
// Assumes rd_byte is the registered RAM output for the current compare step.
module memtest_lane
    import memtest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rd_byte,
    input  logic [7:0] exp_byte,
    input  logic       hold,
    output logic       mism,
    output logic       dead,
    output logic       frozen
);
    logic [7:0] first_q;

    // Keep the first read of a probe pair.
    always_ff @(posedge clk) begin
        if (!rst_n)    first_q <= '0;
        else if (hold) first_q <= rd_byte;
    end

    // Per-half verdicts for the current read.
    always_comb begin
        mism   = (rd_byte != exp_byte);
        dead   = (first_q == FLOAT_BYTE) && (rd_byte == FLOAT_BYTE);
        frozen = (first_q == rd_byte);
    end
endmodule

// File: rtl/dual_lane_memtest.sv
// Self-test sequencer for a two-half 16-bit synchronous SRAM.
// Order: dead-half probe, writability probe, four fill sweeps, address walk.
// Stops on the first fault and holds code/address until reset.
// Assumes read data is valid the cycle after mem_oe and holds until the next read.
module dual_lane_memtest
    import memtest_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pause,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          mem_we,
    output logic          mem_oe,
    output logic [1:0]    mem_be,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [6:0]    fail_code,
    output logic [AW-1:0] fail_addr
);
    localparam int          LW        = (AW > 1) ? $clog2(AW) : 1;
    localparam int unsigned WORD_LAST = (32'd1 << AW) - 32'd1;
    localparam int unsigned LINE_LAST = AW - 1;

    step_t          state, nxt;
    logic [1:0]     prb_q, prb_nxt, fill_q, fill_nxt;
    logic           fail_q;
    logic [6:0]     code_q;
    logic [AW-1:0]  faddr_q;

    logic           clr_a, inc_a, clr_l, inc_l, cap, lat, restart;
    logic [6:0]     f_code;
    logic [AW-1:0]  f_addr;
    logic [15:0]    exp_w;
    logic [AW-1:0]  word_q, line_addr;
    logic [LW-1:0]  line_q;
    logic           word_last, line_last;
    logic [1:0]     mism, dead, frozen;
    logic [7:0]     rd_tag, line_tag;

    memtest_ctr #(.W(AW), .LIMIT(WORD_LAST)) u_word (
        .clk(clk), .rst_n(rst_n), .clr(clr_a), .inc(inc_a),
        .q(word_q), .at_last(word_last)
    );

    memtest_ctr #(.W(LW), .LIMIT(LINE_LAST)) u_line (
        .clk(clk), .rst_n(rst_n), .clr(clr_l), .inc(inc_l),
        .q(line_q), .at_last(line_last)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        memtest_lane u_half (
            .clk(clk), .rst_n(rst_n),
            .rd_byte(mem_rdata[8*h +: 8]), .exp_byte(exp_w[8*h +: 8]),
            .hold(cap), .mism(mism[h]), .dead(dead[h]), .frozen(frozen[h])
        );
    end

    assign line_addr = AW'(1) << line_q;
    assign line_tag  = 8'(line_q) + 8'd1;
    assign rd_tag    = mem_rdata[15:8];

    // Step sequencing, RAM strobes and fault classification.
    always_comb begin
        nxt = state;  prb_nxt = prb_q;  fill_nxt = fill_q;
        clr_a = 1'b0; inc_a = 1'b0; clr_l = 1'b0; inc_l = 1'b0;
        cap = 1'b0;   lat = 1'b0;   restart = 1'b0;
        f_code = CODE_NONE; f_addr = '0;
        exp_w = 16'h0000;
        mem_addr = '0; mem_wdata = 16'h0000; mem_we = 1'b0; mem_oe = 1'b0;
        case (state)
            ST_IDLE, ST_FIN: begin
                if (start && !fail_q) begin
                    restart = 1'b1; nxt = ST_PRB_W;
                    prb_nxt = 2'd0; fill_nxt = 2'd0; clr_a = 1'b1; clr_l = 1'b1;
                end
            end
            ST_PRB_W: begin
                mem_wdata = probe_word(prb_q);
                if (!pause) begin mem_we = 1'b1; nxt = ST_PRB_R; end
            end
            ST_PRB_R: if (!pause) begin mem_oe = 1'b1; nxt = ST_PRB_C; end
            ST_PRB_C: begin
                exp_w = probe_word(prb_q);
                case (prb_q)
                    2'd1: begin
                        if (dead[0])      begin lat = 1'b1; f_code = CODE_DEAD; end
                        else if (dead[1]) begin lat = 1'b1; f_code = CODE_DEAD | 7'd1; end
                        else begin prb_nxt = 2'd2; nxt = ST_PRB_W; end
                    end
                    2'd3: begin
                        if (frozen[0])      begin lat = 1'b1; f_code = CODE_FROZEN; end
                        else if (frozen[1]) begin lat = 1'b1; f_code = CODE_FROZEN | 7'd1; end
                        else begin clr_a = 1'b1; nxt = ST_PAT_W; end
                    end
                    default: begin cap = 1'b1; prb_nxt = prb_q + 2'd1; nxt = ST_PRB_W; end
                endcase
            end
            ST_PAT_W: begin
                mem_addr = word_q; mem_wdata = fill_word(fill_q);
                if (!pause) begin
                    mem_we = 1'b1;
                    if (word_last) begin clr_a = 1'b1; nxt = ST_PAT_R; end
                    else inc_a = 1'b1;
                end
            end
            ST_PAT_R: begin
                mem_addr = word_q;
                if (!pause) begin mem_oe = 1'b1; nxt = ST_PAT_C; end
            end
            ST_PAT_C: begin
                mem_addr = word_q; exp_w = fill_word(fill_q);
                if (|mism) begin
                    lat = 1'b1; f_code = CODE_FILL | {5'd0, fill_q}; f_addr = word_q;
                end else if (word_last) begin
                    clr_a = 1'b1;
                    if (fill_q == 2'd3) begin clr_l = 1'b1; nxt = ST_ADR_W0; end
                    else begin fill_nxt = fill_q + 2'd1; nxt = ST_PAT_W; end
                end else begin
                    inc_a = 1'b1; nxt = ST_PAT_R;
                end
            end
            ST_ADR_W0: begin
                mem_wdata = marker_word(8'd0);
                if (!pause) begin mem_we = 1'b1; nxt = ST_ADR_WL; end
            end
            ST_ADR_WL: begin
                mem_addr = line_addr; mem_wdata = marker_word(line_tag);
                if (!pause) begin
                    mem_we = 1'b1;
                    if (line_last) begin clr_l = 1'b1; nxt = ST_ADR_RL; end
                    else inc_l = 1'b1;
                end
            end
            ST_ADR_RL: begin
                mem_addr = line_addr;
                if (!pause) begin mem_oe = 1'b1; nxt = ST_ADR_CL; end
            end
            ST_ADR_CL: begin
                mem_addr = line_addr; exp_w = marker_word(line_tag);
                if (|mism) begin
                    lat = 1'b1; f_addr = line_addr;
                    f_code = (int'(line_q) < LOW_LINES) ? CODE_ALO : CODE_AHI;
                end else if (line_last) nxt = ST_ADR_R0;
                else begin inc_l = 1'b1; nxt = ST_ADR_RL; end
            end
            ST_ADR_R0: if (!pause) begin mem_oe = 1'b1; nxt = ST_ADR_C0; end
            ST_ADR_C0: begin
                exp_w = marker_word(8'd0);
                if (|mism) begin
                    lat = 1'b1;
                    f_code = (rd_tag != 8'd0 && int'(rd_tag) <= LOW_LINES) ? CODE_ALO : CODE_AHI;
                end else nxt = ST_FIN;
            end
            default: nxt = ST_IDLE;
        endcase
        if (lat) nxt = ST_FIN;
    end

    // Sequencer state and latched fault record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; prb_q <= '0; fill_q <= '0;
            fail_q <= 1'b0; code_q <= CODE_NONE; faddr_q <= '0;
        end else begin
            state <= nxt; prb_q <= prb_nxt; fill_q <= fill_nxt;
            if (lat) begin
                fail_q <= 1'b1; code_q <= f_code; faddr_q <= f_addr;
            end else if (restart) begin
                code_q <= CODE_NONE; faddr_q <= '0;
            end
        end
    end

    // Status outputs.
    assign mem_be    = (mem_we || mem_oe) ? 2'b11 : 2'b00;
    assign busy      = (state != ST_IDLE) && (state != ST_FIN);
    assign done      = (state == ST_FIN);
    assign fail      = fail_q;
    assign fail_code = code_q;
    assign fail_addr = faddr_q;
endmodule

// File: rtl/dual_lane_memtest_chk.sv
// Protocol and status checker for dual_lane_memtest, attached by bind.
// Assumes the synchronous active-low reset is applied before any run.
module dual_lane_memtest_chk #(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pause,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_oe,
    input logic [1:0]    mem_be,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [6:0]    fail_code,
    input logic [AW-1:0] fail_addr
);
    AST_NO_WE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_oe));                                                     // R9
    AST_BE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_oe) |-> mem_be == 2'b11);                                  // R9
    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> !mem_we && !mem_oe);                                            // R8
    AST_PAUSE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) && $past(rst_n) && $past(pause, 2) && $past(pause) && pause
        && $past(busy) && busy |-> $stable(mem_addr));                            // R8
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                                         // R2
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);                                                           // R7
    AST_FAIL_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fail) |-> fail && $stable(fail_code) && $stable(fail_addr)); // R7
    AST_NO_RESTART_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fail) |-> !busy);                                   // R7
    AST_FAIL_CODE_CLASSED: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> fail_code[6]);                                                   // R5
endmodule

bind dual_lane_memtest dual_lane_memtest_chk #(.AW(AW)) u_chk (.*);

// File: tb/dual_lane_memtest_test.sv
// Directed bench: one task per scenario, a fault-injecting RAM model, counters.
module dual_lane_memtest_test;
    localparam int BAW   = 10;
    localparam int WORDS = 1 << BAW;
    localparam int LIMIT = 40000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pause = 1'b0;
    logic [BAW-1:0] mem_addr, fail_addr;
    logic [15:0] mem_wdata, mem_rdata = 16'h0000;
    logic mem_we, mem_oe, busy, done, fail;
    logic [1:0] mem_be;
    logic [6:0] fail_code;

    int checks = 0, errors = 0, clean_len = 0;
    bit finished = 1'b0;
    // Fault model: 0 none, 1 dead half, 2 frozen half (reads 0x3C),
    // 3 stuck data bit, 4 address line tied low, 5 word fpar reads FFFF as FFFE.
    int fmode = 0, fpar = 0;
    logic fval = 1'b0;
    logic [15:0] ram [WORDS];
    logic [BAW-1:0] ea;
    logic [15:0] rd;

    always #5 clk = ~clk;

    dual_lane_memtest #(.AW(BAW)) uut (.*);

    // RAM model with fault injection.
    always @(posedge clk) begin
        ea = mem_addr;
        if (fmode == 4) ea[fpar] = 1'b0;
        if (mem_we) begin
            if (mem_be[0]) ram[ea][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) ram[ea][15:8] <= mem_wdata[15:8];
        end
        if (mem_oe) begin
            rd = ram[ea];
            if (fmode == 1) rd[8*fpar +: 8] = 8'hFF;
            if (fmode == 2) rd[8*fpar +: 8] = 8'h3C;
            if (fmode == 3) rd[fpar] = fval;
            if (fmode == 5 && ea == BAW'(fpar) && rd == 16'hFFFF) rd = 16'hFFFE;
            mem_rdata <= rd;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int mode, input int par, input logic v);
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; pause = 1'b0;
        fmode = mode; fpar = par; fval = v;
        for (int i = 0; i < WORDS; i++) ram[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < LIMIT) begin @(negedge clk); n++; end
        if (!done) chk("R2", "watchdog: run never finished", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        do_reset(0, 0, 1'b0);
        chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
        chk("R1", "fail", fail, 0); chk("R1", "code", fail_code, 0);
        chk("R1", "strobes", {mem_we, mem_oe}, 0);
    endtask

    task automatic t_clean();
        int n;
        do_reset(0, 0, 1'b0);
        pulse_start();
        chk("R2", "busy after start", busy, 1);
        wait_done(n);
        clean_len = n;
        chk("R2", "done", done, 1); chk("R2", "busy at end", busy, 0);
        chk("R2", "fail", fail, 0); chk("R2", "code", fail_code, 0);
        pulse_start();  // R10 restart after a pass
        chk("R10", "busy on restart", busy, 1);
        chk("R10", "done cleared", done, 0);
        wait_done(n);
        chk("R10", "second pass result", {done, fail}, 2'b10);
    endtask

    task automatic t_fault(input string req, input int mode, input int par, input logic v,
                           input logic [6:0] exp_code, input logic [BAW-1:0] exp_addr);
        int n;
        do_reset(mode, par, v);
        pulse_start();
        wait_done(n);
        chk(req, "done", done, 1); chk(req, "fail", fail, 1);
        chk(req, "code", fail_code, exp_code); chk(req, "addr", fail_addr, exp_addr);
    endtask

    task automatic t_sticky();
        logic [6:0] c;
        t_fault("R4", 2, 1, 1'b0, 7'b1110001, '0);
        c = fail_code;
        pulse_start();
        repeat (5) @(negedge clk);
        chk("R7", "busy after ignored start", busy, 0);
        chk("R7", "fail held", {done, fail}, 2'b11);
        chk("R7", "code held", fail_code, c);
    endtask

    task automatic t_pause();
        int n, strobes = 0, ext;
        do_reset(0, 0, 1'b0);
        pulse_start();
        repeat (2000) @(negedge clk);
        pause = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (mem_we || mem_oe) strobes++;
        end
        pause = 1'b0;
        wait_done(n);
        ext = n + 2050 - clean_len;
        chk("R8", "strobes while paused", strobes, 0);
        chk("R8", "run passes after pause", {done, fail}, 2'b10);
        checks++;
        if (ext != 50 && ext != 49) begin
            errors++;
            $display("FAIL R8 pause extension: actual=%0d expected=49 or 50", ext);
        end
    endtask

    initial begin
        #(1900000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: bench hung actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_clean();
        t_fault("R3", 1, 0, 1'b0, 7'b1000100, '0);
        t_fault("R3", 1, 1, 1'b0, 7'b1000101, '0);
        t_fault("R4", 2, 0, 1'b0, 7'b1110000, '0);
        t_sticky();
        t_fault("R5", 3, 3, 1'b1, 7'b1001000, '0);
        t_fault("R5", 3, 0, 1'b0, 7'b1001001, '0);
        t_fault("R5", 3, 9, 1'b0, 7'b1001010, '0);
        t_fault("R5", 5, 'h1A3, 1'b0, 7'b1001011, BAW'('h1A3));
        t_fault("R6", 4, 3, 1'b0, 7'b1010000, '0);
        t_fault("R6", 4, 9, 1'b0, 7'b1010001, '0);
        t_pause();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule